// File: doc/BRIEF.md
# Predicated Vector Reduction Sequencer

This block folds a short vector of elements, held in a small internal register array, into one value. It applies a chosen commutative operation: add, multiply, signed minimum, signed maximum, OR, AND or XOR. Each element is split into independent sub-element lanes, and every lane is folded on its own. A predicate mask selects which element positions take part. The fold visits positions strictly one after another, one position per clock. A reverse bit makes it run from the top position down to position 0.

There are two variants. In vector mode the fold starts from the first unmasked element. The result is written once, at the end, into the destination slot at the lowest unmasked position. In scalar-accumulator mode a single destination register is both the starting value and the target. That register is rewritten after every combining step. An interrupt request can halt the scalar fold after the current element. The block then reports the next element offset, and a later start with the resume bit continues from that offset. After every combining step each lane's partial result is classified as negative, positive or zero. These classifications are merged across steps, either by OR (some step met the condition) or by AND (every step met it).

Top module: `vec_fold_seq`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 multiply (low lane bits), 2 signed minimum, 3 signed maximum, 4 OR, 5 AND, 6 XOR; 7 acts as add.
- R2: With the reverse bit clear, positions run from 0 to VL-1. Element i is read from register `src_base_i + i` (mod NREGS). In vector mode the fold starts from the first unmasked element, and each later unmasked element is combined into the running value.
- R3: Positions whose `pred_i` bit is 0 contribute nothing. In vector mode the only register written is `dst_base_i + f`, where f is the lowest unmasked position below VL. All other registers are left unaltered.
- R4: After each combining step, lane l yields a 3-bit field at `cond_o[3l+2:3l]` = {negative, positive, zero}, taken on the signed lane value. The first step sets the field. Later steps merge by OR when `some_i`=1 and by AND when `some_i`=0. A start clears `cond_o` to 0.
- R5: In vector mode with fewer than two unmasked elements, the single element, if there is one, is copied unchanged, `cond_o` stays 0, and `done_o` still pulses.
- R6: With `rev_i`=1, positions run from VL-1 down to 0.
- R7: With `scalar_i`=1, register `dst_base_i` supplies the starting value and receives the running value after each unmasked element.
- R8: In scalar mode, `irq_i` seen while an element that is not the last is processed stops the fold after that element. `stop_o` pulses, `offs_o` gives the next position, and the destination holds the committed partial value. In vector mode `irq_i` is ignored.
- R9: A start with `resume_i`=1 in scalar mode begins at `resume_offs_i`. It reloads the accumulator from the destination register and does not re-apply earlier positions. The final value equals that of an uninterrupted fold, and `cond_o` covers only the steps after the resume.
- R10: Lanes are independent: a carry or product overflow never crosses from one lane into another.
- R11: `done_o` is a one-cycle pulse N cycles after the start edge, where N is the number of positions visited (0 when nothing is to be visited). `busy_o` is high from the start edge until the cycle after the pulse, and `stop_o` and `done_o` never coincide.
- R12: After reset, `busy_o`, `done_o`, `stop_o`, `cond_o` and `offs_o` are 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | External register write strobe (ignored while busy) |
| wr_addr_i | input | AW | External write address |
| wr_data_i | input | LANES*LANE_W | External write data |
| rd_addr_i | input | AW | External read address |
| rd_data_o | output | LANES*LANE_W | Combinational read data |
| start_i | input | 1 | Start a fold (sampled while idle) |
| resume_i | input | 1 | Resume from `resume_offs_i` (scalar mode only) |
| resume_offs_i | input | IDX_W | Saved position to resume at |
| vl_i | input | VL_W | Vector length |
| pred_i | input | MAX_VL | Predicate, bit i enables position i |
| op_i | input | 3 | Operation code |
| rev_i | input | 1 | Reverse iteration |
| some_i | input | 1 | Condition merge: 1 OR, 0 AND |
| scalar_i | input | 1 | Scalar-accumulator mode |
| src_base_i | input | AW | First source register |
| dst_base_i | input | AW | Destination base register |
| irq_i | input | 1 | Interrupt request |
| busy_o | output | 1 | Fold in progress |
| done_o | output | 1 | Completion pulse |
| stop_o | output | 1 | Interrupted-stop pulse |
| offs_o | output | IDX_W | Position to resume at |
| cond_o | output | LANES*3 | Merged condition fields |

## Verification
The start edge counts as cycle 0. `done_o` is due N cycles later, where N is the number of positions visited. `stop_o` is due p+1 cycles later when the interrupt is raised just before position p is processed. The vector-mode destination write lands on the edge after `done_o`. The bench drives and samples on falling edges and counts falling edges from the start until a pulse appears, so the cycle count is compared exactly with the expected N. It reads `cond_o` and the whole register array only one further falling edge later, when every write has landed. A reference fold in the bench, stepping through positions in the same order, gives the expected array and condition fields for every run. This includes interrupted runs and their resumes.

// File: rtl/vec_fold_pkg.sv
package vec_fold_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_MUL = 3'd1;
  localparam logic [2:0] OP_MIN = 3'd2;
  localparam logic [2:0] OP_MAX = 3'd3;
  localparam logic [2:0] OP_OR  = 3'd4;
  localparam logic [2:0] OP_AND = 3'd5;
  localparam logic [2:0] OP_XOR = 3'd6;

  localparam int COND_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN,
    ST_HALT
  } fold_state_e;
endpackage

// File: rtl/vec_fold_lane.sv
module vec_fold_lane
  import vec_fold_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] y_o,
  output logic [COND_W-1:0] cond_o
);
  logic a_lt_b;
  logic neg, zero;

  assign a_lt_b = $signed(a_i) < $signed(b_i);

  always_comb begin
    case (op_i)
      OP_MUL:  y_o = a_i * b_i;
      OP_MIN:  y_o = a_lt_b ? a_i : b_i;
      OP_MAX:  y_o = a_lt_b ? b_i : a_i;
      OP_OR:   y_o = a_i | b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      default: y_o = a_i + b_i;
    endcase
  end

  assign neg    = y_o[LANE_W-1];
  assign zero   = (y_o == '0);
  assign cond_o = {neg, !neg && !zero, zero};
endmodule

// File: rtl/vec_fold_regs.sv
module vec_fold_regs #(
  parameter int NREGS  = 32,
  parameter int ELEM_W = 16,
  localparam int AW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [ELEM_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [ELEM_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [ELEM_W-1:0] rdata_b_o,
  input  logic [AW-1:0]     raddr_c_i,
  output logic [ELEM_W-1:0] rdata_c_o
);
  logic [ELEM_W-1:0] mem_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
  assign rdata_c_o = mem_q[raddr_c_i];
endmodule

// File: rtl/vec_fold_ctrl.sv
module vec_fold_ctrl
  import vec_fold_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int NREGS  = 32,
  parameter int ELEM_W = 16,
  parameter int CND_W  = 6,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int AW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              resume_i,
  input  logic [IDX_W-1:0]  resume_offs_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic [2:0]        op_i,
  input  logic              rev_i,
  input  logic              some_i,
  input  logic              scalar_i,
  input  logic [AW-1:0]     src_base_i,
  input  logic [AW-1:0]     dst_base_i,
  input  logic              irq_i,
  output logic [AW-1:0]     src_addr_o,
  input  logic [ELEM_W-1:0] src_data_i,
  output logic [AW-1:0]     accin_addr_o,
  input  logic [ELEM_W-1:0] accin_data_i,
  output logic [ELEM_W-1:0] alu_a_o,
  output logic [ELEM_W-1:0] alu_b_o,
  output logic [2:0]        alu_op_o,
  input  logic [ELEM_W-1:0] alu_y_i,
  input  logic [CND_W-1:0]  alu_cond_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [ELEM_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              stop_o,
  output logic [IDX_W-1:0]  offs_o,
  output logic [CND_W-1:0]  cond_o
);
  fold_state_e       state_q;
  logic [IDX_W-1:0]  idx_q, first_q, offs_q;
  logic [VL_W-1:0]   vl_q;
  logic [MAX_VL-1:0] pred_q;
  logic [2:0]        op_q;
  logic              rev_q, some_q, scal_q, any_q, acc_vld_q, cnd_vld_q;
  logic [AW-1:0]     src_q, dst_q;
  logic [ELEM_W-1:0] acc_q;
  logic [CND_W-1:0]  cnd_q;

  // start-time decode
  logic [IDX_W-1:0] st_idx, first_c;
  logic             empty_c, any_c;

  always_comb begin
    any_c   = 1'b0;
    first_c = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (pred_i[i] && (VL_W'(i) < vl_i)) begin
        any_c   = 1'b1;
        first_c = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (resume_i && scalar_i) st_idx = resume_offs_i;
    else if (rev_i)           st_idx = IDX_W'(vl_i - VL_W'(1));
    else                      st_idx = '0;
  end

  assign empty_c = (vl_i == '0) || (VL_W'(st_idx) >= vl_i);

  // per-step decode
  logic             act, last;
  logic [IDX_W-1:0] nxt;
  logic [CND_W-1:0] cnd_mix;

  assign act     = pred_q[idx_q];
  assign last    = rev_q ? (idx_q == '0) : (VL_W'(idx_q) == vl_q - VL_W'(1));
  assign nxt     = rev_q ? idx_q - IDX_W'(1) : idx_q + IDX_W'(1);
  assign cnd_mix = some_q ? (cnd_q | alu_cond_i) : (cnd_q & alu_cond_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      first_q   <= '0;
      offs_q    <= '0;
      vl_q      <= '0;
      pred_q    <= '0;
      op_q      <= '0;
      rev_q     <= 1'b0;
      some_q    <= 1'b0;
      scal_q    <= 1'b0;
      any_q     <= 1'b0;
      acc_vld_q <= 1'b0;
      cnd_vld_q <= 1'b0;
      src_q     <= '0;
      dst_q     <= '0;
      acc_q     <= '0;
      cnd_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            vl_q      <= vl_i;
            pred_q    <= pred_i;
            op_q      <= op_i;
            rev_q     <= rev_i;
            some_q    <= some_i;
            scal_q    <= scalar_i;
            src_q     <= src_base_i;
            dst_q     <= dst_base_i;
            any_q     <= any_c;
            first_q   <= first_c;
            acc_q     <= accin_data_i;
            acc_vld_q <= scalar_i;
            cnd_q     <= '0;
            cnd_vld_q <= 1'b0;
            idx_q     <= st_idx;
            state_q   <= empty_c ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (act) begin
            if (acc_vld_q) begin
              acc_q     <= alu_y_i;
              cnd_q     <= cnd_vld_q ? cnd_mix : alu_cond_i;
              cnd_vld_q <= 1'b1;
            end else begin
              acc_q     <= src_data_i;
              acc_vld_q <= 1'b1;
            end
          end
          if (last) begin
            state_q <= ST_FIN;
          end else if (irq_i && scal_q) begin
            state_q <= ST_HALT;
            offs_q  <= nxt;
          end else begin
            idx_q <= nxt;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign src_addr_o   = src_q + AW'(idx_q);
  assign accin_addr_o = dst_base_i;
  assign alu_a_o      = acc_q;
  assign alu_b_o      = src_data_i;
  assign alu_op_o     = op_q;

  // scalar: commit every step; vector: one write at the end
  logic run_wr, fin_wr;
  assign run_wr    = (state_q == ST_RUN) && act && scal_q;
  assign fin_wr    = (state_q == ST_FIN) && !scal_q && any_q;
  assign wr_en_o   = run_wr || fin_wr;
  assign wr_addr_o = fin_wr ? dst_q + AW'(first_q) : dst_q;
  assign wr_data_o = fin_wr ? acc_q : alu_y_i;

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
  assign stop_o = (state_q == ST_HALT);
  assign offs_o = offs_q;
  assign cond_o = cnd_q;
endmodule

// File: rtl/vec_fold_seq.sv
module vec_fold_seq
  import vec_fold_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int MAX_VL  = 8,
  parameter int NREGS   = 32,
  localparam int ELEM_W = LANES * LANE_W,
  localparam int CND_W  = LANES * COND_W,
  localparam int IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int AW     = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [ELEM_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [ELEM_W-1:0] rd_data_o,
  input  logic              start_i,
  input  logic              resume_i,
  input  logic [IDX_W-1:0]  resume_offs_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic [2:0]        op_i,
  input  logic              rev_i,
  input  logic              some_i,
  input  logic              scalar_i,
  input  logic [AW-1:0]     src_base_i,
  input  logic [AW-1:0]     dst_base_i,
  input  logic              irq_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              stop_o,
  output logic [IDX_W-1:0]  offs_o,
  output logic [CND_W-1:0]  cond_o
);
  logic [AW-1:0]     src_addr, accin_addr, c_waddr, m_waddr;
  logic [ELEM_W-1:0] src_data, accin_data, alu_a, alu_b, alu_y, c_wdata, m_wdata;
  logic [CND_W-1:0]  alu_cnd;
  logic [2:0]        alu_op;
  logic              c_we, m_we;

  // internal writes win; external writes only while idle
  assign m_we    = c_we || (wr_en_i && !busy_o);
  assign m_waddr = c_we ? c_waddr : wr_addr_i;
  assign m_wdata = c_we ? c_wdata : wr_data_i;

  vec_fold_regs #(.NREGS(NREGS), .ELEM_W(ELEM_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (m_we),
    .waddr_i   (m_waddr),
    .wdata_i   (m_wdata),
    .raddr_a_i (src_addr),
    .rdata_a_o (src_data),
    .raddr_b_i (accin_addr),
    .rdata_b_o (accin_data),
    .raddr_c_i (rd_addr_i),
    .rdata_c_o (rd_data_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vec_fold_lane #(.LANE_W(LANE_W)) u_lane (
      .op_i   (alu_op),
      .a_i    (alu_a[l*LANE_W +: LANE_W]),
      .b_i    (alu_b[l*LANE_W +: LANE_W]),
      .y_o    (alu_y[l*LANE_W +: LANE_W]),
      .cond_o (alu_cnd[l*COND_W +: COND_W])
    );
  end

  vec_fold_ctrl #(
    .MAX_VL (MAX_VL),
    .NREGS  (NREGS),
    .ELEM_W (ELEM_W),
    .CND_W  (CND_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .resume_i      (resume_i),
    .resume_offs_i (resume_offs_i),
    .vl_i          (vl_i),
    .pred_i        (pred_i),
    .op_i          (op_i),
    .rev_i         (rev_i),
    .some_i        (some_i),
    .scalar_i      (scalar_i),
    .src_base_i    (src_base_i),
    .dst_base_i    (dst_base_i),
    .irq_i         (irq_i),
    .src_addr_o    (src_addr),
    .src_data_i    (src_data),
    .accin_addr_o  (accin_addr),
    .accin_data_i  (accin_data),
    .alu_a_o       (alu_a),
    .alu_b_o       (alu_b),
    .alu_op_o      (alu_op),
    .alu_y_i       (alu_y),
    .alu_cond_i    (alu_cnd),
    .wr_en_o       (c_we),
    .wr_addr_o     (c_waddr),
    .wr_data_o     (c_wdata),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .stop_o        (stop_o),
    .offs_o        (offs_o),
    .cond_o        (cond_o)
  );
endmodule

// File: rtl/vec_fold_seq_chk.sv
module vec_fold_seq_chk #(
  parameter int OFFS_W = 3,
  parameter int CND_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              irq_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              stop_o,
  input logic [OFFS_W-1:0] offs_o,
  input logic [CND_W-1:0]  cond_o
);
  p_pulse_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && stop_o));

  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_end_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || stop_o) |=> !busy_o);

  p_stop_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> $past(irq_i));

  p_offs_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(offs_o) |-> stop_o);

  p_cond_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(cond_o));
endmodule

bind vec_fold_seq vec_fold_seq_chk #(.OFFS_W(IDX_W), .CND_W(CND_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .irq_i   (irq_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .stop_o  (stop_o),
  .offs_o  (offs_o),
  .cond_o  (cond_o)
);

// File: tb/vec_fold_seq_bench.sv
module vec_fold_seq_bench;
  localparam int NR = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [4:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        start_i = 1'b0, resume_i = 1'b0;
  logic [2:0]  resume_offs_i = '0;
  logic [3:0]  vl_i = '0;
  logic [7:0]  pred_i = '0;
  logic [2:0]  op_i = '0;
  logic        rev_i = 1'b0, some_i = 1'b0, scalar_i = 1'b0, irq_i = 1'b0;
  logic [4:0]  src_base_i = '0, dst_base_i = '0;
  logic        busy_o, done_o, stop_o;
  logic [2:0]  offs_o;
  logic [5:0]  cond_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] model [NR];
  logic [15:0] saved [NR];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk_i = ~clk_i;

  vec_fold_seq u_vec_fold_seq (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .start_i, .resume_i, .resume_offs_i, .vl_i, .pred_i, .op_i, .rev_i,
    .some_i, .scalar_i, .src_base_i, .dst_base_i, .irq_i,
    .busy_o, .done_o, .stop_o, .offs_o, .cond_o
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_ref(input logic [2:0] op, input logic [7:0] a, b);
    case (op)
      3'd1: return a * b;
      3'd2: return ($signed(a) < $signed(b)) ? a : b;
      3'd3: return ($signed(a) > $signed(b)) ? a : b;
      3'd4: return a | b;
      3'd5: return a & b;
      3'd6: return a ^ b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [15:0] elem_ref(input logic [2:0] op, input logic [15:0] a, b);
    return {lane_ref(op, a[15:8], b[15:8]), lane_ref(op, a[7:0], b[7:0])};
  endfunction

  function automatic logic [5:0] cond_ref(input logic [15:0] v);
    logic [5:0] c;
    for (int l = 0; l < 2; l++) begin
      logic [7:0] x;
      x = v[l*8 +: 8];
      c[l*3 +: 3] = {x[7], !x[7] && (x != 0), x == 0};
    end
    return c;
  endfunction

  task automatic wreg(input int a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model[a] = d;
  endtask

  task automatic load_data();
    for (int a = 0; a < NR; a++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      wreg(a, seed[23:8]);
    end
  endtask

  // reference fold over n positions from st; updates model
  task automatic ref_fold(input int op, vl, input logic [7:0] pred, input bit rev, some,
                          scal, input int src, dst, st, n, input bit stopped,
                          output logic [5:0] cnd);
    logic [15:0] acc;
    bit vld, cv, any;
    int first;
    acc = scal ? model[dst] : '0;
    vld = scal; cv = 0; cnd = '0;
    for (int k = 0; k < n; k++) begin
      int idx;
      logic [4:0] ad;
      idx = rev ? st - k : st + k;
      ad  = 5'(src + idx);
      if (pred[idx]) begin
        if (vld) begin
          acc = elem_ref(3'(op), acc, model[ad]);
          cnd = cv ? (some ? (cnd | cond_ref(acc)) : (cnd & cond_ref(acc))) : cond_ref(acc);
          cv  = 1;
          if (scal) model[dst] = acc;
        end else begin
          acc = model[ad];
          vld = 1;
        end
      end
    end
    any = 0; first = 0;
    for (int i = 7; i >= 0; i--) if (pred[i] && i < vl) begin any = 1; first = i; end
    if (!scal && any && !stopped) model[5'(dst + first)] = acc;
  endtask

  task automatic cmp_regs(input string tag);
    bit ok;
    logic [15:0] ba, be;
    ok = 1; ba = '0; be = '0;
    for (int a = 0; a < NR; a++) begin
      rd_addr_i = 5'(a);
      #1;
      if (ok && rd_data_o !== model[a]) begin ok = 0; ba = rd_data_o; be = model[a]; end
    end
    chk(ok, tag, "register array", ba, be);
  endtask

  task automatic exec(input int op, vl, input logic [7:0] pred, input bit rev, some, scal,
                      resume, input int roffs, irq_pos, input bit irq_hold,
                      input string tag, output int offs_got);
    int st, ntot, n, nxt, cyc;
    bit empty, stopped;
    logic [5:0] ecnd;
    st      = (resume && scal) ? roffs : (rev ? vl - 1 : 0);
    empty   = (vl == 0) || (st >= vl);
    ntot    = empty ? 0 : (rev ? st + 1 : vl - st);
    stopped = scal && irq_pos >= 0 && irq_pos < ntot - 1;
    n       = stopped ? irq_pos + 1 : ntot;
    nxt     = rev ? st - n : st + n;
    ref_fold(op, vl, pred, rev, some, scal, 2, 20, st, n, stopped, ecnd);
    @(negedge clk_i);
    op_i = 3'(op); vl_i = 4'(vl); pred_i = pred; rev_i = rev; some_i = some;
    scalar_i = scal; resume_i = resume; resume_offs_i = 3'(roffs);
    src_base_i = 5'd2; dst_base_i = 5'd20; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; irq_i = irq_hold; cyc = 0;
    while (!done_o && !stop_o && cyc < 40) begin
      if (irq_pos >= 0 && cyc == irq_pos) irq_i = 1'b1;
      @(negedge clk_i);
      irq_i = irq_hold;
      cyc++;
    end
    irq_i = 1'b0;
    chk(cyc == n, "R11", {tag, " cycles to pulse"}, cyc, n);
    chk(stop_o == stopped && done_o == !stopped, stopped ? "R8" : "R11",
        {tag, " pulse kind"}, {done_o, stop_o}, {!stopped, stopped});
    if (stopped) chk(offs_o == 3'(nxt), "R8", {tag, " saved offset"}, offs_o, 3'(nxt));
    offs_got = int'(offs_o);
    @(negedge clk_i);
    chk(cond_o == ecnd, "R4", {tag, " condition"}, cond_o, ecnd);
    chk(!busy_o, "R11", {tag, " idle after pulse"}, busy_o, 0);
    cmp_regs(tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int og;
    logic [15:0] full;
    for (int a = 0; a < NR; a++) model[a] = '0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !stop_o, "R12", "flags in reset", {busy_o, done_o, stop_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cond_o == 0 && offs_o == 0, "R12", "cond/offs after reset", {cond_o, offs_o}, 0);
    cmp_regs("R12");

    // sweep: every op, direction, merge mode, variant, length and mask pattern
    for (int op = 0; op < 7; op++)
      for (int rv = 0; rv < 2; rv++)
        for (int sm = 0; sm < 2; sm++)
          for (int sc = 0; sc < 2; sc++) begin
            load_data();
            for (int vi = 0; vi < 5; vi++)
              for (int pi = 0; pi < 5; pi++) begin
                int vls [5] = '{1, 2, 3, 5, 8};
                logic [7:0] pats [5] = '{8'hFF, 8'hA5, 8'h10, 8'h00, 8'h6C};
                string tg;
                tg = $sformatf("R1/%s op%0d", sc ? "R7" : (rv ? "R6" : "R2"), op);
                exec(op, vls[vi], pats[pi], rv[0], sm[0], sc[0], 0, 0, -1, 0, tg, og);
              end
          end

    // every mask over four positions
    load_data();
    for (int p = 0; p < 16; p++) begin
      exec(0, 4, 8'(p), 0, 1, 0, 0, 0, -1, 0, "R3 vec", og);
      exec(3, 4, 8'(p) | 8'hF0, 1, 0, 1, 0, 0, -1, 0, "R3 scal", og);
    end

    // single unmasked element and zero length
    exec(1, 8, 8'h04, 0, 0, 0, 0, 0, -1, 0, "R5 single", og);
    exec(0, 0, 8'hFF, 0, 0, 0, 0, 0, -1, 0, "R5 empty", og);

    // lane independence with lane 0 overflowing
    for (int i = 0; i < 4; i++) wreg(2 + i, 16'h0180);
    exec(0, 4, 8'h0F, 0, 1, 0, 0, 0, -1, 0, "R10 add", og);
    for (int i = 0; i < 4; i++) wreg(2 + i, 16'h03F1);
    exec(1, 4, 8'h0F, 0, 1, 0, 0, 0, -1, 0, "R10 mul", og);

    // interrupt ignored in vector mode
    load_data();
    exec(0, 8, 8'hFF, 0, 1, 0, 0, 0, -1, 1, "R8 vec irq", og);

    // interrupt, then resume
    for (int rv = 0; rv < 2; rv++)
      for (int op = 0; op < 4; op += 3)
        for (int p = 0; p < 7; p++) begin
          logic [5:0] dc;
          load_data();
          saved = model;
          ref_fold(op, 8, 8'hDB, rv[0], 1, 1, 2, 20, rv ? 7 : 0, 8, 0, dc);
          full  = model[20];
          model = saved;
          exec(op, 8, 8'hDB, rv[0], 1, 1, 0, 0, p, 0, "R8 stop", og);
          exec(op, 8, 8'hDB, rv[0], 1, 1, 1, og, -1, 0, "R9 resume", og);
          rd_addr_i = 5'd20;
          #1;
          chk(rd_data_o == full, "R9", "resumed equals uninterrupted", rd_data_o, full);
        end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule